// File: doc/BRIEF.md
# Return-Address Stack with Optional Shadow Restore

This block holds the return addresses of a small 8-bit processor core and carries out its return-from-subroutine instruction. A 16-bit instruction word arrives with a valid strobe. If the word is the return opcode, the block starts a two-cycle sequence. In the first cycle it removes the newest stack entry and loads it into the program counter. The second cycle is an idle slot. The lowest opcode bit is a shadow-select flag. When that flag is set, the same pop also reloads the working register, the status register and the bank-select register from a one-deep shadow copy. When the flag is clear, those three registers keep their values.

The call side is modelled by a push port. Each accepted push stores a full program-counter-wide address on top of the stack. It can optionally snapshot the three architectural registers into the shadow copy. An architectural write port sets the working, status and bank registers and the upper program-counter latch. A return never alters the latch. The stack depth is a parameter (31 by default). Popping an empty stack and pushing onto a full one each set a sticky error flag, and neither event moves the pointer.

The controller is a three-state machine. `S_IDLE` accepts work. The transition `S_IDLE -> S_POP` is taken on a valid return opcode. `S_POP` performs the pop and the optional restore. The transition `S_POP -> S_SLOT` always follows. `S_SLOT` is the idle second cycle. The transition `S_SLOT -> S_IDLE` always follows.

Top module: `rstk_return_unit`

## Requirements
- R1: After reset, pc, sp, the working, status, bank and latch registers, the shadow copy, both error flags and busy are all zero.
- R2: Only an instruction word whose upper 15 bits equal 15'h0009 (words 16'h0012 and 16'h0013) starts a return. Any other word leaves busy low and all state unchanged.
- R3: A return accepted at clock edge k raises busy after edge k. It updates pc and sp at edge k+1 and drops busy at edge k+2, so the instruction takes two cycles.
- R4: A return on a non-empty stack loads pc with the newest stored address and decrements sp by one. Entries leave in last-in, first-out order.
- R5: When bit 0 of the return word is 1, the working, status and bank registers take the shadow values at the pop edge.
- R6: When bit 0 of the return word is 0, the working, status and bank registers keep their values through the return.
- R7: The upper program-counter latch is never changed by a return.
- R8: A push accepted in S_IDLE with sp below DEPTH stores push_addr at the top and increments sp. With push_shadow set, the push copies the current working, status and bank values into the shadow.
- R9: A return with sp equal to 0 sets the sticky underflow flag and leaves pc and sp unchanged. The shadow restore still follows bit 0.
- R10: A push with sp equal to DEPTH sets the sticky overflow flag and leaves sp and the stored entries unchanged.
- R11: While busy is high, push requests and instruction words are ignored. If a return opcode and a push arrive together in S_IDLE, the return is taken and the push is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Instruction word strobe |
| instr_word | input | 16 | Instruction word |
| push_valid | input | 1 | Push request |
| push_addr | input | PC_W | Address to push |
| push_shadow | input | 1 | Snapshot the architectural registers into the shadow on push |
| arch_we | input | 1 | Architectural register write strobe |
| arch_w | input | W_W | New working register value |
| arch_status | input | ST_W | New status register value |
| arch_bsr | input | BSR_W | New bank-select value |
| arch_pclat | input | LAT_W | New upper program-counter latch value |
| pc | output | PC_W | Program counter |
| w_reg | output | W_W | Working register |
| status_reg | output | ST_W | Status register |
| bsr_reg | output | BSR_W | Bank-select register |
| pclat_reg | output | LAT_W | Upper program-counter latch |
| sp | output | SP_W | Stack pointer (number of entries held) |
| busy | output | 1 | Return sequence in progress |
| underflow | output | 1 | Sticky pop-on-empty flag |
| overflow | output | 1 | Sticky push-on-full flag |

## Verification
A stuck or wrongly sequenced state machine shows first on busy. The busy pulse would stretch past two cycles, start on a non-return word or never start, and this is visible one edge after the instruction is offered. A pointer off by one appears on the very next return, because pc takes a neighbouring entry, and on the sp port at once. A shadow copy taken at the wrong time appears only on the first restoring return after it. Corrupted stack storage appears only when the damaged entry reaches the top, so the bench drains deep stacks in order.

// File: rtl/rstk_pkg.sv
package rstk_pkg;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_POP  = 2'd1,
        S_SLOT = 2'd2
    } rstk_state_e;

    // return opcode: upper 15 bits fixed, bit 0 selects shadow restore
    localparam logic [14:0] RET_OPC_HI = 15'h0009;

endpackage

// File: rtl/rstk_decode.sv
module rstk_decode (
    input  logic        instr_valid,
    input  logic [15:0] instr_word,
    output logic        is_ret,
    output logic        shadow_sel
);
    import rstk_pkg::*;

    always_comb begin
        is_ret     = instr_valid && (instr_word[15:1] == RET_OPC_HI);
        shadow_sel = instr_word[0];
    end

endmodule

// File: rtl/rstk_store.sv
module rstk_store #(
    parameter int DEPTH = 31,
    parameter int PC_W  = 21,
    localparam int SP_W  = $clog2(DEPTH + 1),
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push_req,
    input  logic [PC_W-1:0] push_addr,
    input  logic            pop_req,
    output logic [PC_W-1:0] tos,
    output logic            tos_ok,
    output logic [SP_W-1:0] sp,
    output logic            unf,
    output logic            ovf
);
    localparam logic [SP_W-1:0] SP_FULL = SP_W'(DEPTH);

    logic [PC_W-1:0] mem [DEPTH];
    logic [SP_W-1:0] sp_q;
    logic            unf_q;
    logic            ovf_q;
    logic            full;
    logic            empty;
    logic [SP_W-1:0] top_pos;

    always_comb begin
        full    = (sp_q == SP_FULL);
        empty   = (sp_q == '0);
        top_pos = sp_q - SP_W'(1);
    end

    // one write port per entry, selected by the pointer
    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (push_req && !full && (sp_q == SP_W'(g))) begin
                mem[g] <= push_addr;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_q  <= '0;
            unf_q <= 1'b0;
            ovf_q <= 1'b0;
        end else if (pop_req) begin
            if (empty) begin
                unf_q <= 1'b1;
            end else begin
                sp_q <= top_pos;
            end
        end else if (push_req) begin
            if (full) begin
                ovf_q <= 1'b1;
            end else begin
                sp_q <= sp_q + SP_W'(1);
            end
        end
    end

    always_comb begin
        tos_ok = !empty;
        tos    = empty ? '0 : mem[top_pos[IDX_W-1:0]];
    end

    assign sp  = sp_q;
    assign unf = unf_q;
    assign ovf = ovf_q;

endmodule

// File: rtl/rstk_shadow.sv
module rstk_shadow #(
    parameter int W_W   = 8,
    parameter int ST_W  = 8,
    parameter int BSR_W = 4,
    parameter int LAT_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic             restore,
    input  logic             arch_we,
    input  logic [W_W-1:0]   arch_w,
    input  logic [ST_W-1:0]  arch_status,
    input  logic [BSR_W-1:0] arch_bsr,
    input  logic [LAT_W-1:0] arch_pclat,
    output logic [W_W-1:0]   w_reg,
    output logic [ST_W-1:0]  status_reg,
    output logic [BSR_W-1:0] bsr_reg,
    output logic [LAT_W-1:0] pclat_reg
);
    logic [W_W-1:0]   w_q,   w_sh;
    logic [ST_W-1:0]  st_q,  st_sh;
    logic [BSR_W-1:0] bsr_q, bsr_sh;
    logic [LAT_W-1:0] lat_q;

    // architectural registers: restore outranks a software write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_q   <= '0;
            st_q  <= '0;
            bsr_q <= '0;
            lat_q <= '0;
        end else begin
            if (restore) begin
                w_q   <= w_sh;
                st_q  <= st_sh;
                bsr_q <= bsr_sh;
            end else if (arch_we) begin
                w_q   <= arch_w;
                st_q  <= arch_status;
                bsr_q <= arch_bsr;
            end
            if (arch_we) begin
                lat_q <= arch_pclat;
            end
        end
    end

    // one-deep shadow copy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_sh   <= '0;
            st_sh  <= '0;
            bsr_sh <= '0;
        end else if (capture) begin
            w_sh   <= w_q;
            st_sh  <= st_q;
            bsr_sh <= bsr_q;
        end
    end

    assign w_reg      = w_q;
    assign status_reg = st_q;
    assign bsr_reg    = bsr_q;
    assign pclat_reg  = lat_q;

endmodule

// File: rtl/rstk_return_unit.sv
module rstk_return_unit #(
    parameter int DEPTH = 31,
    parameter int PC_W  = 21,
    parameter int W_W   = 8,
    parameter int ST_W  = 8,
    parameter int BSR_W = 4,
    parameter int LAT_W = 13,
    localparam int SP_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             instr_valid,
    input  logic [15:0]      instr_word,
    input  logic             push_valid,
    input  logic [PC_W-1:0]  push_addr,
    input  logic             push_shadow,
    input  logic             arch_we,
    input  logic [W_W-1:0]   arch_w,
    input  logic [ST_W-1:0]  arch_status,
    input  logic [BSR_W-1:0] arch_bsr,
    input  logic [LAT_W-1:0] arch_pclat,
    output logic [PC_W-1:0]  pc,
    output logic [W_W-1:0]   w_reg,
    output logic [ST_W-1:0]  status_reg,
    output logic [BSR_W-1:0] bsr_reg,
    output logic [LAT_W-1:0] pclat_reg,
    output logic [SP_W-1:0]  sp,
    output logic             busy,
    output logic             underflow,
    output logic             overflow
);
    import rstk_pkg::*;

    rstk_state_e     state_q, state_d;
    logic            sel_q;
    logic            is_ret, shadow_sel;
    logic            start;
    logic            pop_req, push_req, restore, capture;
    logic [PC_W-1:0] tos;
    logic            tos_ok;
    logic [PC_W-1:0] pc_q;

    rstk_decode u_decode (
        .instr_valid (instr_valid),
        .instr_word  (instr_word),
        .is_ret      (is_ret),
        .shadow_sel  (shadow_sel)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (is_ret) state_d = S_POP;
            S_POP:   state_d = S_SLOT;
            S_SLOT:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            sel_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == S_IDLE && is_ret) begin
                sel_q <= shadow_sel;
            end
        end
    end

    // output / control decode
    always_comb begin
        start    = 1'b0;
        pop_req  = 1'b0;
        restore  = 1'b0;
        push_req = 1'b0;
        busy     = 1'b1;
        unique case (state_q)
            S_IDLE: begin
                busy     = 1'b0;
                start    = is_ret;
                push_req = push_valid && !is_ret;
            end
            S_POP: begin
                pop_req = 1'b1;
                restore = sel_q;
            end
            S_SLOT: begin
                pop_req = 1'b0;
            end
            default: begin
                busy = 1'b0;
            end
        endcase
        capture = push_req && push_shadow;
    end

    rstk_store #(
        .DEPTH (DEPTH),
        .PC_W  (PC_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_req  (push_req),
        .push_addr (push_addr),
        .pop_req   (pop_req),
        .tos       (tos),
        .tos_ok    (tos_ok),
        .sp        (sp),
        .unf       (underflow),
        .ovf       (overflow)
    );

    rstk_shadow #(
        .W_W   (W_W),
        .ST_W  (ST_W),
        .BSR_W (BSR_W),
        .LAT_W (LAT_W)
    ) u_shadow (
        .clk         (clk),
        .rst_n       (rst_n),
        .capture     (capture),
        .restore     (restore),
        .arch_we     (arch_we),
        .arch_w      (arch_w),
        .arch_status (arch_status),
        .arch_bsr    (arch_bsr),
        .arch_pclat  (arch_pclat),
        .w_reg       (w_reg),
        .status_reg  (status_reg),
        .bsr_reg     (bsr_reg),
        .pclat_reg   (pclat_reg)
    );

    // program counter: loaded from the stack top at the pop edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= '0;
        end else if (pop_req && tos_ok) begin
            pc_q <= tos;
        end
    end

    assign pc = pc_q;

    logic unused_start;
    assign unused_start = start;

endmodule

// File: rtl/rstk_return_unit_chk.sv
module rstk_return_unit_chk #(
    parameter int DEPTH = 31,
    parameter int PC_W  = 21,
    parameter int W_W   = 8,
    parameter int ST_W  = 8,
    parameter int BSR_W = 4,
    parameter int LAT_W = 13,
    localparam int SP_W = $clog2(DEPTH + 1)
) (
    input logic                 clk,
    input logic                 rst_n,
    input rstk_pkg::rstk_state_e state,
    input logic                 sel,
    input logic                 instr_valid,
    input logic [15:0]          instr_word,
    input logic                 push_valid,
    input logic                 arch_we,
    input logic [PC_W-1:0]      pc,
    input logic [W_W-1:0]       w_reg,
    input logic [ST_W-1:0]      status_reg,
    input logic [BSR_W-1:0]     bsr_reg,
    input logic [LAT_W-1:0]     pclat_reg,
    input logic [SP_W-1:0]      sp,
    input logic                 busy,
    input logic                 underflow,
    input logic                 overflow
);
    import rstk_pkg::*;

    localparam logic [SP_W-1:0] SP_FULL = SP_W'(DEPTH);

    // R2: a non-return word in idle does not start a sequence
    a_r2_ignore_other: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && !(instr_valid && instr_word[15:1] == RET_OPC_HI)) |=> !busy);

    // R3: busy lasts exactly two cycles
    a_r3_two_cycles: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |=> busy ##1 !busy);

    // R4: pop on non-empty stack decrements pointer
    a_r4_pop_dec: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_POP && sp != '0) |=> sp == $past(sp) - SP_W'(1));

    // R6: no restore leaves registers alone
    a_r6_hold_regs: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_POP && !sel && !arch_we) |=>
        ($stable(w_reg) && $stable(status_reg) && $stable(bsr_reg)));

    // R7: latch untouched by a return
    a_r7_latch_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !arch_we) |=> $stable(pclat_reg));

    // R9: pop on empty keeps pc and sp, sets flag
    a_r9_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_POP && sp == '0) |=> (underflow && sp == '0 && $stable(pc)));

    // R10: push on full keeps sp, sets flag
    a_r10_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && push_valid && sp == SP_FULL &&
         !(instr_valid && instr_word[15:1] == RET_OPC_HI)) |=> (overflow && $stable(sp)));

    // R11: nothing moves the pointer in the idle slot
    a_r11_slot_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_SLOT) |=> $stable(sp));

    // R9/R10: sticky flags never clear outside reset
    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |=> underflow);
    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

endmodule

bind rstk_return_unit rstk_return_unit_chk #(
    .DEPTH (DEPTH),
    .PC_W  (PC_W),
    .W_W   (W_W),
    .ST_W  (ST_W),
    .BSR_W (BSR_W),
    .LAT_W (LAT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .state       (state_q),
    .sel         (sel_q),
    .instr_valid (instr_valid),
    .instr_word  (instr_word),
    .push_valid  (push_valid),
    .arch_we     (arch_we),
    .pc          (pc),
    .w_reg       (w_reg),
    .status_reg  (status_reg),
    .bsr_reg     (bsr_reg),
    .pclat_reg   (pclat_reg),
    .sp          (sp),
    .busy        (busy),
    .underflow   (underflow),
    .overflow    (overflow)
);

// File: tb/rstk_return_unit_bench.sv
module rstk_return_unit_bench;
    localparam int DEPTH = 31;
    localparam int PC_W  = 21;
    localparam int SP_W  = $clog2(DEPTH + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             instr_valid = 1'b0;
    logic [15:0]      instr_word = '0;
    logic             push_valid = 1'b0;
    logic [PC_W-1:0]  push_addr = '0;
    logic             push_shadow = 1'b0;
    logic             arch_we = 1'b0;
    logic [7:0]       arch_w = '0;
    logic [7:0]       arch_status = '0;
    logic [3:0]       arch_bsr = '0;
    logic [12:0]      arch_pclat = '0;
    logic [PC_W-1:0]  pc;
    logic [7:0]       w_reg, status_reg;
    logic [3:0]       bsr_reg;
    logic [12:0]      pclat_reg;
    logic [SP_W-1:0]  sp;
    logic             busy, underflow, overflow;

    always #2.5 clk = ~clk;

    rstk_return_unit u_rstk_return_unit (
        .clk (clk), .rst_n (rst_n),
        .instr_valid (instr_valid), .instr_word (instr_word),
        .push_valid (push_valid), .push_addr (push_addr), .push_shadow (push_shadow),
        .arch_we (arch_we), .arch_w (arch_w), .arch_status (arch_status),
        .arch_bsr (arch_bsr), .arch_pclat (arch_pclat),
        .pc (pc), .w_reg (w_reg), .status_reg (status_reg), .bsr_reg (bsr_reg),
        .pclat_reg (pclat_reg), .sp (sp), .busy (busy),
        .underflow (underflow), .overflow (overflow)
    );

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // reference model
    logic [PC_W-1:0] m_stk [DEPTH];
    int              m_sp = 0;
    logic [PC_W-1:0] m_pc = '0;
    logic [7:0]      m_w = '0, m_st = '0, m_w_sh = '0, m_st_sh = '0;
    logic [3:0]      m_bsr = '0, m_bsr_sh = '0;
    logic [12:0]     m_lat = '0;
    bit              m_unf = 0, m_ovf = 0;

    function automatic bit is_return_word(input logic [15:0] wd);
        return (wd & 16'hFFFE) == 16'h0012;
    endfunction

    function automatic logic [15:0] other_word(input logic [15:0] r);
        return is_return_word(r) ? (r ^ 16'h0100) : r;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_all(input string tag);
        chk({tag, " pc"}, 32'(pc), 32'(m_pc));
        chk({tag, " sp"}, 32'(sp), 32'(m_sp));
        chk({tag, " w"}, 32'(w_reg), 32'(m_w));
        chk({tag, " status"}, 32'(status_reg), 32'(m_st));
        chk({tag, " bsr"}, 32'(bsr_reg), 32'(m_bsr));
        chk({tag, " latch R7"}, 32'(pclat_reg), 32'(m_lat));
        chk({tag, " underflow R9"}, 32'(underflow), 32'(m_unf));
        chk({tag, " overflow R10"}, 32'(overflow), 32'(m_ovf));
        chk({tag, " busy"}, 32'(busy), 32'd0);
    endtask

    task automatic do_push(input logic [PC_W-1:0] a, input bit shd);
        push_valid = 1'b1; push_addr = a; push_shadow = shd;
        @(negedge clk);
        push_valid = 1'b0; push_shadow = 1'b0;
        if (shd) begin m_w_sh = m_w; m_st_sh = m_st; m_bsr_sh = m_bsr; end
        if (m_sp == DEPTH) m_ovf = 1;
        else begin m_stk[m_sp] = a; m_sp++; end
    endtask

    task automatic do_arch(input logic [7:0] w, input logic [7:0] s, input logic [3:0] b,
                           input logic [12:0] l);
        arch_we = 1'b1; arch_w = w; arch_status = s; arch_bsr = b; arch_pclat = l;
        @(negedge clk);
        arch_we = 1'b0;
        m_w = w; m_st = s; m_bsr = b; m_lat = l;
    endtask

    // return with optional push / instr overlap while busy (R11)
    task automatic do_ret(input bit s, input bit disturb);
        instr_valid = 1'b1; instr_word = {15'h0009, s};
        @(negedge clk);
        chk("R3 busy after accept", 32'(busy), 32'd1);
        chk("R3 pc not yet loaded", 32'(pc), 32'(m_pc));
        if (disturb) begin
            push_valid = 1'b1; push_addr = 21'h1ABCD; push_shadow = 1'b1;
            instr_word = 16'h0013;
        end else begin
            instr_valid = 1'b0;
        end
        if (m_sp == 0) m_unf = 1;
        else begin m_sp--; m_pc = m_stk[m_sp]; end
        if (s) begin m_w = m_w_sh; m_st = m_st_sh; m_bsr = m_bsr_sh; end
        @(negedge clk);
        chk("R3 busy second cycle", 32'(busy), 32'd1);
        chk("R4 pc loaded at pop", 32'(pc), 32'(m_pc));
        chk("R4 sp after pop", 32'(sp), 32'(m_sp));
        chk(s ? "R5 w restored" : "R6 w kept", 32'(w_reg), 32'(m_w));
        instr_valid = 1'b0; push_valid = 1'b0; push_shadow = 1'b0;
        @(negedge clk);
        chk("R3 busy dropped", 32'(busy), 32'd0);
        chk("R11 sp unchanged by busy push", 32'(sp), 32'(m_sp));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_all("R1 reset");

        // R9: return on empty stack, with restore of zero shadow
        do_ret(1'b1, 1'b0);
        chk_all("R9 empty pop");

        // R2: non-return words ignored
        instr_valid = 1'b1; instr_word = 16'h0011;
        @(negedge clk);
        chk("R2 0011 ignored", 32'(busy), 32'd0);
        instr_word = 16'h8012;
        @(negedge clk);
        chk("R2 8012 ignored", 32'(busy), 32'd0);
        instr_valid = 1'b0; instr_word = 16'h0012;
        @(negedge clk);
        chk("R2 invalid strobe ignored", 32'(busy), 32'd0);
        chk_all("R2 state");

        // R8 / R5 / R6: shadow capture then restore
        do_arch(8'hA5, 8'h1F, 4'h3, 13'h1234);
        do_push(21'h0ABCD, 1'b1);
        do_arch(8'h11, 8'h02, 4'hC, 13'h0777);
        do_push(21'h1F00F, 1'b0);
        chk_all("R8 pushes");
        do_ret(1'b0, 1'b0);
        chk_all("R6 no restore");
        do_ret(1'b1, 1'b0);
        chk_all("R5 restore");

        // R11: push and return offered together in idle: return wins
        do_push(21'h00042, 1'b0);
        instr_valid = 1'b1; instr_word = 16'h0012;
        push_valid = 1'b1; push_addr = 21'h12345;
        @(negedge clk);
        push_valid = 1'b0; instr_valid = 1'b0;
        m_sp--; m_pc = m_stk[m_sp];
        @(negedge clk); @(negedge clk);
        chk_all("R11 return beats push");

        // R11: disturbance while busy
        do_push(21'h00777, 1'b0);
        do_ret(1'b0, 1'b1);
        chk_all("R11 busy ignores");

        // R10: fill and overflow, then drain LIFO (R4)
        for (int i = 0; i < DEPTH; i++) do_push(PC_W'(21'h100 + i * 3), 1'b0);
        chk("R10 full sp", 32'(sp), 32'(DEPTH));
        do_push(21'h1DEAD, 1'b0);
        chk_all("R10 overflow");
        for (int i = 0; i < DEPTH; i++) do_ret(1'b0, 1'b0);
        chk_all("R4 drained");

        // constrained random mix
        void'($urandom(32'd77));
        for (int n = 0; n < 400; n++) begin
            int op;
            op = int'($urandom_range(0, 9));
            if (op < 4) do_push(PC_W'($urandom), 1'($urandom));
            else if (op < 7) do_ret(1'($urandom), 1'($urandom_range(0, 3) == 0));
            else if (op < 9) do_arch(8'($urandom), 8'($urandom), 4'($urandom), 13'($urandom));
            else begin
                instr_valid = 1'b1; instr_word = other_word(16'($urandom));
                @(negedge clk);
                instr_valid = 1'b0;
                chk("R2 random word ignored", 32'(busy), 32'd0);
            end
            chk_all("random");
        end
        done = 1'b1;
    end

    initial begin
        int cyc;
        cyc = 0;
        while (!done && cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog: actual=%0d expected=done", cyc);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule